// File: doc/BRIEF.md
# Resizable BAR Sizing Register Unit

This unit keeps the configuration state that decides how large each Base Address Register (BAR) of one PCIe endpoint function is. Every BAR is tied at build time to one of three sizing schemes. A fixed BAR takes its mask from a build-time constant. A programmable BAR takes its mask from a hidden shadow register, into which local firmware writes the size minus one. A resizable BAR takes its mask from a selected-size field inside a Resizable BAR extended capability. Bit 0 of each shadow register switches its BAR on. The unit drives the effective address mask and the enable of every BAR to the address-match logic.

A single register port reaches two views. The normal view holds the BAR dwords, the capability and control dwords, and a misc dword that carries the read-only write-enable gate. The shadow view (`shadow_i` high) holds the mask registers. Two resets apply. `rst_ni` clears everything. The synchronous `warm_rst_i` clears only the non-sticky state: the selected sizes, the BAR address bits and the write gate. The advertised sizes, the shadow masks and the BAR flag bits survive it. Even-numbered BARs can pair with the next BAR to form a 64-bit BAR.

Top module: `rebar_sizing_unit`

## Requirements
- R1: After `rst_ni` all BAR enables and masks are zero, BAR and misc dwords read 0, each capability dword reads 0x0000_0010 and each control dword reads its BAR index in bits 2:0 and the resizable-entry count in bits 7:5 (default map: capability/control at dwords 0x41/0x42 for BAR0 and 0x43/0x44 for BAR5).
- R2: Shadow writes, BAR flag bits 3:0, capability writes and control bits 31:16 take effect only while bit 0 of the misc dword (0x3F) is 1.
- R3: A programmable BAR holds the written shadow word. Bit 0 is its enable, and its mask is the inverse of (shadow OR 0xF).
- R4: For a fixed BAR only shadow bit 0 is writable. Its shadow view reads the build-time size-minus-one with bit 0 replaced by the enable, and its mask is the inverse of (constant OR 0xF).
- R5: For a resizable BAR only shadow bit 0 is writable. Its mask is the inverse of (2^(20+s) - 1), where s is control bits 13:8, and the shadow view reads that value with bit 0 replaced by the enable.
- R6: A gated capability write stores bits 31:4 (bits 3:0 read 0), where bit k means 2^(16+k) bytes. If any of those bits is set, s becomes the index of the lowest set bit minus 4. A value of zero leaves s unchanged.
- R7: A control write sets s from bits 13:8 without needing the gate, and the mask follows in the next cycle.
- R8: When an even BAR has flags bits 2:0 = 3'b100, the next BAR is its upper half. The upper half's enable follows the lower one. Its mask is the inverse of its own shadow word, or the upper word of the resizable size minus one. It reads back all 32 bits as address.
- R9: A BAR whose enable is 0 reads 0 in the normal view and drives a zero mask.
- R10: A normal BAR dword reads (written address AND mask) OR flags, so writing all ones returns the size.
- R11: `warm_rst_i` clears s, the BAR address bits and the gate. It keeps the capabilities, control bits 31:16, shadow masks and flags. A gated capability write in the same cycle still lands, but s ends at 0.
- R12: Reads return data and `rvalid_o` one cycle after `req_i`. Shadow-view addresses that are not BARs read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low full reset |
| warm_rst_i | input | 1 | Synchronous non-sticky reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| shadow_i | input | 1 | 1 = shadow mask view |
| addr_i | input | ADDR_W | Dword address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| bar_en_o | output | NUM_BARS | BAR enables |
| bar_mask_o | output | NUM_BARS*32 | Effective address masks, BAR n at bits 32n+31:32n |

## Verification
A gated capability write and a warm reset can occur in the same cycle. The write would move the selected size, and the reset would clear it. The bench drives a capability write of 0x3000 together with the `warm_rst_i` pulse. It then requires that the capability reads 0x3000, that the control dword shows a selected size of 0, and that the write gate reads clear. Separate checks confirm that shadow masks and the other entry's state survive the same pulse and that the mask recomputes from the cleared size.

// File: rtl/rebar_pkg.sv
package rebar_pkg;
  typedef enum logic [1:0] {
    SCH_FIXED = 2'd0,
    SCH_PROG  = 2'd1,
    SCH_RESZ  = 2'd2
  } scheme_e;

  localparam int unsigned SIZE_LOG2_MIN = 20;
  localparam int unsigned CAP_LSB       = 4;

  // index of lowest set bit of the advertised-size field
  function automatic logic [5:0] lowest_size(input logic [27:0] bits);
    logic [5:0] r;
    r = '0;
    for (int i = 27; i >= 0; i--) begin
      if (bits[i]) r = 6'(i);
    end
    return r;
  endfunction

  // size minus one for selected size code
  function automatic logic [63:0] size_m1(input logic [5:0] sel);
    logic [6:0] sh;
    sh = {1'b0, sel} + 7'(SIZE_LOG2_MIN);
    if (sh > 7'd63) return '1;
    return (64'd1 << sh) - 64'd1;
  endfunction
endpackage

// File: rtl/rebar_entry.sv
module rebar_entry
  import rebar_pkg::*;
#(
  parameter int unsigned BAR_IDX = 0,
  parameter int unsigned NBAR    = 1,
  parameter logic [31:0] CAP_RST = 32'h0000_0010,
  parameter logic [15:0] HI_RST  = 16'h0000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        warm_rst_i,
  input  logic        ro_wr_en_i,
  input  logic        wr_cap_i,
  input  logic        wr_ctrl_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] cap_o,
  output logic [31:0] ctrl_o,
  output logic [63:0] m1_o
);
  logic [27:0] cap_q;
  logic [15:0] hi_q;
  logic [5:0]  sel_q;
  logic        cap_we;

  assign cap_we = wr_cap_i && ro_wr_en_i;

  // sticky fields
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= CAP_RST[31:4];
      hi_q  <= HI_RST;
    end else begin
      if (cap_we) cap_q <= wdata_i[31:4];
      if (wr_ctrl_i && ro_wr_en_i) hi_q <= wdata_i[31:16];
    end
  end

  // non-sticky selected size
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (warm_rst_i) sel_q <= '0;
    else if (cap_we && (|wdata_i[31:4])) sel_q <= lowest_size(wdata_i[31:4]);
    else if (wr_ctrl_i) sel_q <= wdata_i[13:8];
  end

  assign cap_o  = {cap_q, 4'b0000};
  assign ctrl_o = {hi_q, 2'b00, sel_q, 3'(NBAR), 2'b00, 3'(BAR_IDX)};
  assign m1_o   = size_m1(sel_q);

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[7:0], wdata_i[15:14]};

  // R6
  sel_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> $past(wr_cap_i || wr_ctrl_i || warm_rst_i));
  // R11
  warm_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> (sel_q == 6'd0));
  // R11
  warm_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_rst_i && !cap_we) |=> $stable(cap_q));
endmodule

// File: rtl/bar_slot.sv
module bar_slot
  import rebar_pkg::*;
#(
  parameter scheme_e     SCHEME   = SCH_PROG,
  parameter logic [31:0] FIXED_M1 = 32'h0000_0FFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        warm_rst_i,
  input  logic        ro_wr_en_i,
  input  logic        wr_norm_i,
  input  logic        wr_shad_i,
  input  logic [31:0] wdata_i,
  input  logic        is_upper_i,
  input  logic        pair_en_i,
  input  logic        use_ext_i,
  input  logic [31:0] ext_m1_i,
  output logic [31:0] norm_rdata_o,
  output logic [31:0] shad_rdata_o,
  output logic        en_o,
  output logic [31:0] mask_o,
  output logic [2:0]  flags_o
);
  logic [31:0] shadow_q;
  logic [3:0]  flags_q;
  logic [31:0] addr_q;
  logic [31:0] m1;
  logic [31:0] m1_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (wr_shad_i && ro_wr_en_i) begin
      if (SCHEME == SCH_PROG) shadow_q <= wdata_i;
      else shadow_q[0] <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else if (wr_norm_i && ro_wr_en_i) flags_q <= wdata_i[3:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (warm_rst_i) addr_q <= '0;
    else if (wr_norm_i) addr_q <= wdata_i;
  end

  always_comb begin
    if (use_ext_i) m1 = ext_m1_i;
    else begin
      case (SCHEME)
        SCH_FIXED: m1 = FIXED_M1;
        SCH_PROG:  m1 = shadow_q;
        default:   m1 = '1;
      endcase
    end
  end

  assign m1_eff       = is_upper_i ? m1 : (m1 | 32'h0000_000F);
  assign en_o         = is_upper_i ? pair_en_i : shadow_q[0];
  assign mask_o       = en_o ? ~m1_eff : '0;
  assign shad_rdata_o = is_upper_i ? m1 : {m1[31:1], shadow_q[0]};
  assign flags_o      = flags_q[2:0];

  always_comb begin
    if (!en_o) norm_rdata_o = '0;
    else if (is_upper_i) norm_rdata_o = addr_q & mask_o;
    else norm_rdata_o = (addr_q & mask_o) | {28'b0, flags_q};
  end

  // R2
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_shad_i && ro_wr_en_i) |=> $stable(shadow_q));
  // R2
  flags_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_norm_i && ro_wr_en_i) |=> $stable(flags_q));
endmodule

// File: rtl/rebar_sizing_unit.sv
module rebar_sizing_unit
  import rebar_pkg::*;
#(
  parameter int unsigned NUM_BARS   = 6,
  parameter int unsigned NUM_REBAR  = 2,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BAR_BASE   = 4,
  parameter int unsigned MISC_ADDR  = 'h3F,
  parameter int unsigned REBAR_BASE = 'h40,
  parameter logic [NUM_BARS*2-1:0]  BAR_SCHEME = 12'b10_00_01_01_01_10,
  parameter logic [NUM_BARS*32-1:0] FIXED_M1   = {6{32'h0000_0FFF}},
  parameter logic [NUM_REBAR*3-1:0] REBAR_BAR  = {3'd5, 3'd0},
  parameter logic [31:0]            CAP_RST    = 32'h0000_0010
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   warm_rst_i,
  input  logic                   req_i,
  input  logic                   we_i,
  input  logic                   shadow_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [31:0]            wdata_i,
  output logic [31:0]            rdata_o,
  output logic                   rvalid_o,
  output logic [NUM_BARS-1:0]    bar_en_o,
  output logic [NUM_BARS*32-1:0] bar_mask_o
);
  localparam int unsigned ENTRY_STRIDE = 2;

  logic        ro_wr_en_q;
  logic        misc_hit;
  logic [31:0] rdata_q, rd_next;
  logic        rvalid_q;

  logic [NUM_BARS-1:0] hit_bar, is_upper, lower64, pair_en, use_ext;
  logic [31:0] norm_rd [NUM_BARS];
  logic [31:0] shad_rd [NUM_BARS];
  logic [31:0] ext_m1  [NUM_BARS];
  logic [2:0]  flags   [NUM_BARS];

  logic [NUM_REBAR-1:0] cap_hit, ctrl_hit;
  logic [31:0] cap_rd  [NUM_REBAR];
  logic [31:0] ctrl_rd [NUM_REBAR];
  logic [63:0] m1_e    [NUM_REBAR];

  assign misc_hit = (addr_i == ADDR_W'(MISC_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ro_wr_en_q <= 1'b0;
    else if (warm_rst_i) ro_wr_en_q <= 1'b0;
    else if (req_i && we_i && !shadow_i && misc_hit) ro_wr_en_q <= wdata_i[0];
  end

  for (genvar e = 0; e < NUM_REBAR; e++) begin : g_entry
    assign cap_hit[e]  = (addr_i == ADDR_W'(REBAR_BASE + 1 + ENTRY_STRIDE*e));
    assign ctrl_hit[e] = (addr_i == ADDR_W'(REBAR_BASE + 2 + ENTRY_STRIDE*e));

    rebar_entry #(
      .BAR_IDX(int'(REBAR_BAR[e*3 +: 3])),
      .NBAR   (NUM_REBAR),
      .CAP_RST(CAP_RST),
      .HI_RST (16'h0000)
    ) u_entry (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .warm_rst_i(warm_rst_i),
      .ro_wr_en_i(ro_wr_en_q),
      .wr_cap_i  (req_i && we_i && !shadow_i && cap_hit[e]),
      .wr_ctrl_i (req_i && we_i && !shadow_i && ctrl_hit[e]),
      .wdata_i   (wdata_i),
      .cap_o     (cap_rd[e]),
      .ctrl_o    (ctrl_rd[e]),
      .m1_o      (m1_e[e])
    );
  end

  for (genvar n = 0; n < NUM_BARS; n++) begin : g_bar
    assign hit_bar[n] = (addr_i == ADDR_W'(BAR_BASE + n));

    if ((n % 2 == 0) && (n + 1 < NUM_BARS)) begin : g_low
      assign lower64[n] = (flags[n] == 3'b100);
    end else begin : g_nolow
      assign lower64[n] = 1'b0;
    end

    if (n % 2 == 1) begin : g_up
      assign is_upper[n] = lower64[n-1];
      assign pair_en[n]  = bar_en_o[n-1];
      // R8
      pair_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_upper[n] |-> (bar_en_o[n] == bar_en_o[n-1]));
    end else begin : g_noup
      assign is_upper[n] = 1'b0;
      assign pair_en[n]  = 1'b0;
    end

    bar_slot #(
      .SCHEME  (scheme_e'(BAR_SCHEME[n*2 +: 2])),
      .FIXED_M1(FIXED_M1[n*32 +: 32])
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .warm_rst_i  (warm_rst_i),
      .ro_wr_en_i  (ro_wr_en_q),
      .wr_norm_i   (req_i && we_i && !shadow_i && hit_bar[n]),
      .wr_shad_i   (req_i && we_i && shadow_i && hit_bar[n]),
      .wdata_i     (wdata_i),
      .is_upper_i  (is_upper[n]),
      .pair_en_i   (pair_en[n]),
      .use_ext_i   (use_ext[n]),
      .ext_m1_i    (ext_m1[n]),
      .norm_rdata_o(norm_rd[n]),
      .shad_rdata_o(shad_rd[n]),
      .en_o        (bar_en_o[n]),
      .mask_o      (bar_mask_o[n*32 +: 32]),
      .flags_o     (flags[n])
    );
  end

  // route resizable size to its BAR, upper word to the paired BAR
  always_comb begin
    for (int n = 0; n < NUM_BARS; n++) begin
      use_ext[n] = 1'b0;
      ext_m1[n]  = '0;
      for (int e = 0; e < NUM_REBAR; e++) begin
        if (int'(REBAR_BAR[e*3 +: 3]) == n) begin
          use_ext[n] = 1'b1;
          ext_m1[n]  = m1_e[e][31:0];
        end else if (is_upper[n] && (int'(REBAR_BAR[e*3 +: 3]) == n - 1)) begin
          use_ext[n] = 1'b1;
          ext_m1[n]  = m1_e[e][63:32];
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (!shadow_i && misc_hit) rd_next = {31'b0, ro_wr_en_q};
    for (int n = 0; n < NUM_BARS; n++) begin
      if (hit_bar[n]) rd_next = shadow_i ? shad_rd[n] : norm_rd[n];
    end
    for (int e = 0; e < NUM_REBAR; e++) begin
      if (!shadow_i && cap_hit[e])  rd_next = cap_rd[e];
      if (!shadow_i && ctrl_hit[e]) rd_next = ctrl_rd[e];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= req_i && !we_i;
      if (req_i && !we_i) rdata_q <= rd_next;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R12
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  // R11
  warm_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_rst_i |=> !ro_wr_en_q);
endmodule

// File: tb/rebar_sizing_unit_bench.sv
`timescale 1ns/1ps
module rebar_sizing_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        warm = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic        shd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [5:0]  en;
  logic [191:0] mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rebar_sizing_unit u_rebar_sizing_unit (
    .clk_i(clk), .rst_ni(rst_n), .warm_rst_i(warm), .req_i(req), .we_i(we),
    .shadow_i(shd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rvalid_o(rvalid), .bar_en_o(en), .bar_mask_o(mask)
  );

  localparam logic [7:0] A_MISC = 8'h3F;
  localparam logic [7:0] A_CAP0 = 8'h41, A_CTL0 = 8'h42, A_CAP1 = 8'h43, A_CTL1 = 8'h44;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic v, input logic [7:0] a, input logic [31:0] d, input logic wrst);
    @(negedge clk);
    req = 1'b1; we = 1'b1; shd = v; addr = a; wdata = d; warm = wrst;
    @(negedge clk);
    req = 1'b0; we = 1'b0; warm = 1'b0;
  endtask

  task automatic rd(input logic v, input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; shd = v; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
    chk("R12 rvalid", {31'b0, rvalid}, 32'd1);
  endtask

  function automatic logic [31:0] mk(input int n);
    return mask[n*32 +: 32];
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 enables", {26'b0, en}, 32'd0);
    for (int n = 0; n < 6; n++) chk("R1 mask", mk(n), 32'd0);
    rd(1'b0, 8'h04, d); chk("R1 bar0 read", d, 32'd0);
    rd(1'b0, A_MISC, d); chk("R1 gate", d, 32'd0);
    rd(1'b0, A_CAP0, d); chk("R1 cap0", d, 32'h10);
    rd(1'b0, A_CTL0, d); chk("R1 ctrl0", d, 32'h40);
    rd(1'b0, A_CTL1, d); chk("R1 ctrl1", d, 32'h45);
    rd(1'b1, A_CAP0, d); chk("R12 shadow nonbar", d, 32'd0);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    wr(1'b1, 8'h05, 32'h0000_FFFF, 1'b0);
    rd(1'b1, 8'h05, d); chk("R2 shadow gated", d, 32'd0);
    chk("R2 bar1 disabled", {31'b0, en[1]}, 32'd0);
    wr(1'b0, A_CAP0, 32'h0000_0100, 1'b0);
    rd(1'b0, A_CAP0, d); chk("R2 cap gated", d, 32'h10);
    rd(1'b0, A_CTL0, d); chk("R2 sel unchanged", d, 32'h40);
  endtask

  task automatic t_prog;
    logic [31:0] d;
    wr(1'b0, A_MISC, 32'h1, 1'b0);
    wr(1'b1, 8'h06, 32'h0000_FFFF, 1'b0);
    chk("R3 bar2 enable", {31'b0, en[2]}, 32'd1);
    chk("R3 bar2 mask", mk(2), 32'hFFFF_0000);
    wr(1'b0, 8'h06, 32'h0000_0008, 1'b0);
    rd(1'b0, 8'h06, d); chk("R10 flags only", d, 32'h0000_0008);
    wr(1'b0, A_MISC, 32'h0, 1'b0);
    wr(1'b0, 8'h06, 32'hFFFF_FFFF, 1'b0);
    rd(1'b0, 8'h06, d); chk("R10 sizing read", d, 32'hFFFF_0008);
    rd(1'b1, 8'h06, d); chk("R3 shadow read", d, 32'h0000_FFFF);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    wr(1'b0, A_MISC, 32'h1, 1'b0);
    wr(1'b1, 8'h08, 32'hFFFF_FFFF, 1'b0);
    rd(1'b1, 8'h08, d); chk("R4 fixed shadow", d, 32'h0000_0FFF);
    chk("R4 fixed mask", mk(4), 32'hFFFF_F000);
    chk("R4 fixed enable", {31'b0, en[4]}, 32'd1);
  endtask

  task automatic t_resz;
    logic [31:0] d;
    wr(1'b1, 8'h04, 32'h0000_0001, 1'b0);
    chk("R5 bar0 1MB mask", mk(0), 32'hFFF0_0000);
    wr(1'b0, A_CAP0, 32'h0000_0F00, 1'b0);
    chk("R6 auto sel mask", mk(0), 32'hFF00_0000);
    rd(1'b0, A_CAP0, d); chk("R6 cap read", d, 32'h0000_0F00);
    rd(1'b0, A_CTL0, d); chk("R6 sel field", d, 32'h0000_0440);
    wr(1'b0, A_MISC, 32'h0, 1'b0);
    wr(1'b0, A_CTL0, 32'hFFFF_0600, 1'b0);
    rd(1'b0, A_CTL0, d); chk("R7 ctrl ungated sel, hi gated", d, 32'h0000_0640);
    chk("R7 mask follows", mk(0), 32'hFC00_0000);
    rd(1'b1, 8'h04, d); chk("R5 shadow derived", d, 32'h03FF_FFFF);
    wr(1'b0, A_MISC, 32'h1, 1'b0);
    wr(1'b0, A_CTL0, 32'h1234_0600, 1'b0);
    rd(1'b0, A_CTL0, d); chk("R2 ctrl hi gated write", d, 32'h1234_0640);
    wr(1'b0, A_CAP0, 32'h0, 1'b0);
    rd(1'b0, A_CTL0, d); chk("R6 zero cap keeps sel", d, 32'h1234_0640);
  endtask

  task automatic t_pair;
    logic [31:0] d;
    wr(1'b0, 8'h04, 32'h0000_0004, 1'b0);
    wr(1'b0, A_CTL0, 32'h1234_0E00, 1'b0);
    chk("R8 resz lower mask", mk(0), 32'h0000_0000);
    chk("R8 resz upper mask", mk(1), 32'hFFFF_FFFC);
    chk("R8 resz upper en", {31'b0, en[1]}, 32'd1);
    wr(1'b0, 8'h06, 32'h0000_0004, 1'b0);
    wr(1'b1, 8'h06, 32'hFFFF_FFFF, 1'b0);
    wr(1'b1, 8'h07, 32'h0000_0001, 1'b0);
    chk("R8 prog lower mask", mk(2), 32'h0000_0000);
    chk("R8 prog upper mask", mk(3), 32'hFFFF_FFFE);
    wr(1'b0, 8'h07, 32'hFFFF_FFFF, 1'b0);
    rd(1'b0, 8'h07, d); chk("R8 upper address read", d, 32'hFFFF_FFFE);
    rd(1'b0, 8'h06, d); chk("R10 64-bit flags", d, 32'h0000_0004);
    wr(1'b1, 8'h06, 32'hFFFF_FFFE, 1'b0);
    chk("R9 lower off", {31'b0, en[2]}, 32'd0);
    chk("R9 upper follows off", {31'b0, en[3]}, 32'd0);
    chk("R9 upper mask zero", mk(3), 32'd0);
    rd(1'b0, 8'h07, d); chk("R9 upper reads zero", d, 32'd0);
  endtask

  task automatic t_warm;
    logic [31:0] d;
    wr(1'b0, A_CAP1, 32'h0000_3000, 1'b1);
    rd(1'b0, A_CAP1, d); chk("R11 cap written in warm cycle", d, 32'h0000_3000);
    rd(1'b0, A_CTL1, d); chk("R11 sel cleared by warm", d, 32'h0000_0045);
    rd(1'b0, A_MISC, d); chk("R11 gate cleared", d, 32'd0);
    rd(1'b0, A_CTL0, d); chk("R11 ctrl hi kept", d, 32'h1234_0040);
    rd(1'b1, 8'h06, d); chk("R11 shadow kept", d, 32'hFFFF_FFFE);
    chk("R11 bar0 mask recomputed", mk(0), 32'hFFF0_0000);
    chk("R11 bar1 upper mask", mk(1), 32'hFFFF_FFFF);
    rd(1'b0, 8'h04, d); chk("R11 address cleared flags kept", d, 32'h0000_0004);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_prog();
    t_fixed();
    t_resz();
    t_pair();
    t_warm();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule